// File: doc/BRIEF.md
# Flash Read Accelerator with Programmable Wait States

The block sits between a processor read port and a slow flash array. Each read takes a number of clock cycles that software sets to match the core frequency. Two line-wide holding latches keep recently fetched flash lines. One latch is filled by instruction fetches and the other by data reads. A read that the current mode lets the latches serve completes in one cycle and does not touch the flash.

Software programs two small fields through a write strobe. A 2-bit mode selects off, partial or full acceleration. A 3-bit access-time field sets the flash access length. In partial mode only sequential instruction fetches can be served from the latches. In full mode any read whose line is held in either latch is served. Any write that really changes the mode drops every latch, so the reads after it fetch fresh flash contents.

Top module: `flash_accel`

## Requirements
- R1: After reset the mode is off (00), both latches are invalid, and `rd_ready` and `fl_req` are low. The first read after reset goes to flash.
- R2: A mode write (`cfg_sel`=0) takes `cfg_wdata[1:0]`, where 00 is off, 01 is partial and 10 is full. A write of 11 is ignored and leaves the mode and the latches unchanged.
- R3: A read that misses takes T+1 cycles from the first rising edge that samples `rd_valid` until `rd_ready` is seen. T is the access-time field (`cfg_sel`=1, `cfg_wdata[2:0]`), and the value 0 counts as 7. During a miss `fl_req` is high for exactly T cycles and `fl_addr` holds the line address `rd_addr[7:2]`.
- R4: A write to the access-time field while a flash access is in progress does not change that access. It applies from the next access on.
- R5: In off mode every read goes to flash, including repeated reads of the same line.
- R6: In full mode a read whose line is held in either latch completes one cycle after it is sampled, and `fl_req` stays low.
- R7: In partial mode only an instruction fetch (`rd_ifetch`=1) marked sequential (`rd_seq`=1) whose line is in the instruction latch is served from the latches. Data reads and non-sequential fetches always go to flash.
- R8: A mode write whose value is different from the current mode invalidates both latches.
- R9: A mode write that repeats the current mode keeps the latch contents.
- R10: `rd_ready` is a single-cycle pulse. While it is high, `rd_data` carries word `rd_addr[1:0]` of line `rd_addr[7:2]`.
- R11: A missed instruction fetch fills only the instruction latch, and a missed data read fills only the data latch. Neither kind of fill evicts the other latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the mode field, 1 selects the access-time field |
| cfg_wdata | input | 3 | Configuration write data |
| rd_valid | input | 1 | Read request, held until `rd_ready` |
| rd_addr | input | AW | Word address of the read |
| rd_ifetch | input | 1 | 1 for an instruction fetch, 0 for a data read |
| rd_seq | input | 1 | Fetch follows the previous fetch sequentially |
| rd_ready | output | 1 | Read completes this cycle |
| rd_data | output | DW | Read data, valid with `rd_ready` |
| fl_req | output | 1 | Flash access in progress |
| fl_addr | output | AW-LWL | Flash line address |
| fl_rdata | input | DW<<LWL | Flash line data, valid by the end of the access |

## Verification
The embedded assertions check on every cycle that the reserved mode never takes effect and that a mode change leaves both latches empty. They also check that the flash address stays steady during an access, that the wait counter counts down without skipping, and that off-mode and partial-mode data responses always come after a flash access. The bench scenarios are the only place that exact latencies are measured for every access-time value. They also show that hits skip the flash completely, that a timing write made in the middle of an access is deferred, and that writing 11 or repeating the current mode leaves the latches in place.

// File: rtl/flash_accel.sv
module flash_accel #(
  parameter int AW  = 8,
  parameter int DW  = 32,
  parameter int LWL = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic                  cfg_sel,
  input  logic [2:0]            cfg_wdata,
  input  logic                  rd_valid,
  input  logic [AW-1:0]         rd_addr,
  input  logic                  rd_ifetch,
  input  logic                  rd_seq,
  output logic                  rd_ready,
  output logic [DW-1:0]         rd_data,
  output logic                  fl_req,
  output logic [AW-LWL-1:0]     fl_addr,
  input  logic [(DW<<LWL)-1:0]  fl_rdata
);
  localparam int LAW = AW - LWL;
  localparam int LDW = DW << LWL;

  typedef enum logic [1:0] {IDLE, WAIT, RESP} st_t;
  st_t state;

  logic [1:0]     mode_q;
  logic [2:0]     tim_q, cnt;
  logic           iv, dv, req_if;
  logic [LAW-1:0] itag, dtag;
  logic [LDW-1:0] iline, dline;
  logic [AW-1:0]  req_addr;
  logic [DW-1:0]  out_data;

  wire [LAW-1:0] line   = rd_addr[AW-1:LWL];
  wire [LWL-1:0] word   = rd_addr[LWL-1:0];
  wire           ihit   = iv && itag == line;
  wire           dhit   = dv && dtag == line;
  wire           use_hit = (mode_q == 2'b10) ? (ihit || dhit)
                         : (mode_q == 2'b01) ? (rd_ifetch && rd_seq && ihit)
                         : 1'b0;
  wire [LDW-1:0] hit_line = ihit ? iline : dline;
  wire [2:0]     eff_tim  = (tim_q == 3'd0) ? 3'd7 : tim_q;
  wire           mode_chg = cfg_we && !cfg_sel && cfg_wdata[1:0] != 2'b11
                            && cfg_wdata[1:0] != mode_q;

  assign rd_ready = state == RESP;
  assign rd_data  = out_data;
  assign fl_req   = state == WAIT;
  assign fl_addr  = req_addr[AW-1:LWL];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 2'b00;
      tim_q  <= 3'd0;
    end else if (cfg_we) begin
      if (cfg_sel) tim_q <= cfg_wdata;
      else if (cfg_wdata[1:0] != 2'b11) mode_q <= cfg_wdata[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= IDLE;
      cnt      <= 3'd0;
      iv       <= 1'b0;
      dv       <= 1'b0;
      itag     <= '0;
      dtag     <= '0;
      iline    <= '0;
      dline    <= '0;
      req_addr <= '0;
      req_if   <= 1'b0;
      out_data <= '0;
    end else begin
      case (state)
        IDLE: if (rd_valid) begin
          if (use_hit) begin
            out_data <= hit_line[word*DW +: DW];
            state    <= RESP;
          end else begin
            req_addr <= rd_addr;
            req_if   <= rd_ifetch;
            cnt      <= eff_tim;
            state    <= WAIT;
          end
        end
        WAIT: if (cnt == 3'd1) begin
          out_data <= fl_rdata[req_addr[LWL-1:0]*DW +: DW];
          if (mode_q != 2'b00) begin
            if (req_if) begin
              iv    <= 1'b1;
              itag  <= req_addr[AW-1:LWL];
              iline <= fl_rdata;
            end else begin
              dv    <= 1'b1;
              dtag  <= req_addr[AW-1:LWL];
              dline <= fl_rdata;
            end
          end
          state <= RESP;
        end else begin
          cnt <= cnt - 3'd1;
        end
        default: state <= IDLE;
      endcase
      if (mode_chg) begin
        iv <= 1'b0;
        dv <= 1'b0;
      end
    end
  end

  a_r2_no_reserved_mode: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != 2'b11);

  a_r8_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel && cfg_wdata[1:0] != 2'b11 && cfg_wdata[1:0] != mode_q)
    |=> (!iv && !dv));

  a_r3_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && $past(fl_req)) |-> $stable(fl_addr));

  a_r3_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WAIT && $past(state == WAIT)) |-> (cnt == $past(cnt) - 3'd1 && cnt != 3'd0));

  a_r5_off_goes_to_flash: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && $past(mode_q == 2'b00)) |-> $past(fl_req));

  a_r7_partial_data_misses: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && $past(mode_q == 2'b01 && !rd_ifetch)) |-> $past(fl_req));

  a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |=> !rd_ready);
endmodule

// File: tb/sim_flash_accel.sv
`timescale 1ns/1ps
module sim_flash_accel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [2:0]  cfg_wdata = 3'd0;
  logic        rd_valid = 1'b0, rd_ifetch = 1'b0, rd_seq = 1'b0;
  logic [7:0]  rd_addr = 8'd0;
  logic        rd_ready, fl_req;
  logic [31:0] rd_data;
  logic [5:0]  fl_addr;
  logic [127:0] fl_rdata;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] fword(input logic [5:0] ln, input int w);
    return {2'b00, ln, 8'(w), 8'(ln) ^ 8'hA5, 8'(w) + 8'h3C};
  endfunction

  always_comb
    for (int i = 0; i < 4; i++) fl_rdata[i*32 +: 32] = fword(fl_addr, i);

  flash_accel u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_ifetch(rd_ifetch), .rd_seq(rd_seq), .rd_ready(rd_ready), .rd_data(rd_data),
    .fl_req(fl_req), .fl_addr(fl_addr), .fl_rdata(fl_rdata));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int eff(input int t);
    return (t == 0) ? 7 : t;
  endfunction

  task automatic wcfg(input bit sel, input int v);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = 3'(v);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int a, input bit ifc, input bit sq, input int mid_tim,
                    input int exp_lat, input string req);
    int lat = 0, fc = 0;
    bit done = 0, bad_addr = 0;
    logic [31:0] d = '0;
    rd_addr = 8'(a); rd_ifetch = ifc; rd_seq = sq; rd_valid = 1'b1;
    while (!done && lat < 40) begin
      @(posedge clk); #1;
      lat++;
      if (lat == 1 && mid_tim >= 0) begin
        cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 3'(mid_tim);
      end else if (lat == 2) cfg_we = 1'b0;
      if (fl_req) begin
        fc++;
        if (fl_addr != 6'(a >> 2)) bad_addr = 1;
      end
      if (rd_ready) begin
        done = 1; d = rd_data;
      end
    end
    cfg_we = 1'b0;
    rd_valid = 1'b0;
    chk(lat == exp_lat, {req, " latency"}, lat, exp_lat);
    chk(d == fword(6'(a >> 2), a & 3), "R10 data", d, fword(6'(a >> 2), a & 3));
    chk(fc == exp_lat - 1, {req, " flash cycles"}, fc, exp_lat - 1);
    chk(!bad_addr, "R3 flash line address", bad_addr, 0);
    @(posedge clk); #1;
    chk(!rd_ready, "R10 ready single pulse", rd_ready, 0);
  endtask

  initial begin
    #50000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!rd_ready, "R1 ready low in reset", rd_ready, 0);
    chk(!fl_req, "R1 fl_req low in reset", fl_req, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    rd(8'h10, 1, 1, -1, 8, "R1 first read off");
    rd(8'h10, 1, 1, -1, 8, "R5 repeat off");

    for (int t = 0; t < 8; t++) begin
      wcfg(1, t);
      wcfg(0, 0);
      rd(8'h20 + t, 0, 0, -1, eff(t) + 1, "R3 off sweep");
      rd(8'h20 + t, 1, 1, -1, eff(t) + 1, "R5 off repeat");
      wcfg(0, 2);
      rd(8'h40 + 4*t, 1, 0, -1, eff(t) + 1, "R3 full miss");
      for (int w = 0; w < 4; w++)
        rd(8'h40 + 4*t + w, w[0], 0, -1, 1, "R6 full hit");
    end

    wcfg(1, 3);
    rd(8'h80, 1, 1, -1, 4, "R11 ifetch fill");
    rd(8'h90, 0, 0, -1, 4, "R11 data fill");
    rd(8'h81, 1, 1, -1, 1, "R11 instruction latch kept");
    rd(8'h92, 0, 0, -1, 1, "R11 data latch kept");
    rd(8'h93, 1, 0, -1, 1, "R6 fetch hits data latch");

    wcfg(0, 3);
    rd(8'h82, 0, 0, -1, 1, "R2 reserved write ignored");
    wcfg(0, 2);
    rd(8'h91, 0, 0, -1, 1, "R9 same mode keeps latches");

    wcfg(0, 1);
    rd(8'h80, 1, 1, -1, 4, "R8 change to partial invalidates");
    rd(8'h81, 1, 1, -1, 1, "R7 partial seq fetch hit");
    rd(8'h82, 1, 0, -1, 4, "R7 partial nonseq miss");
    rd(8'hA0, 0, 0, -1, 4, "R7 partial data miss");
    rd(8'hA1, 0, 0, -1, 4, "R7 partial data repeat miss");
    rd(8'hA2, 1, 1, -1, 4, "R7 partial seq fetch in data latch");

    wcfg(0, 2);
    rd(8'hA2, 1, 1, -1, 4, "R8 change to full invalidates");
    wcfg(0, 0);
    rd(8'hA2, 1, 1, -1, 4, "R5 off after full");

    wcfg(1, 2);
    rd(8'hB0, 0, 0, 5, 3, "R4 mid-access timing write deferred");
    rd(8'hB4, 0, 0, -1, 6, "R4 new timing on next access");
    wcfg(1, 1);
    rd(8'hB8, 0, 0, 0, 2, "R4 mid write of 0 deferred");
    rd(8'hBC, 0, 0, -1, 8, "R3 zero means seven");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule